// File: doc/BRIEF.md
# Binary Add/Subtract Flag Unit

This block performs the binary add-with-carry and subtract-with-borrow of an 8-bit accumulator-style datapath and produces the four arithmetic flags of a packed status byte. The caller presents the current accumulator, the current status byte, an operand and an operation select, then pulses a valid strobe. On the next rising clock edge the unit captures the new accumulator value and the updated status byte. Between strobes both outputs hold.

Subtraction has no separate subtractor. The operand is inverted bit by bit and fed into the same adder, together with the incoming carry. The carry flag therefore acts as an inverted borrow. The overflow flag follows the signed-range rule: it is set when the true signed result does not fit in 8 bits. A change of sign alone does not set it. Status bits that the unit does not own, including the decimal-mode bit, pass through untouched. Arithmetic is always binary.

Top module: `asf_unit`

## Requirements
- R1: Synchronous reset, active high, sets `acc_out` to 0x00 and `status_out` to 0x24.
- R2: With `op_sub`=0, a valid strobe produces `acc_out` = (`acc_in` + `operand` + C) mod 256. C is bit 0 of `status_in` before the operation.
- R3: Let the adder inputs be `acc_in` and the effective operand. V (status bit 6) is set when the signed sum of these inputs plus C lies outside -128..+127, and is cleared otherwise. Adder inputs of opposite sign never set V.
- R4: With `op_sub`=1, the result is (`acc_in` + (`operand` XOR 0xFF) + C) mod 256. This equals `acc_in` - `operand` - (1 - C).
- R5: C (status bit 0) is bit 8 of the 9-bit unsigned sum. For subtraction, C=1 means no borrow occurred.
- R6: N (status bit 7) equals bit 7 of the new accumulator. Z (status bit 1) is 1 exactly when the new accumulator is 0x00.
- R7: Status bits 5, 4, 3 and 2 are copied from `status_in`. Bit 3 (decimal mode) has no effect on the arithmetic.
- R8: In a cycle without `in_valid`, `acc_out` and `status_out` keep their values, whatever the other inputs do.
- R9: An add of 0x7F and 0x80 with `status_in` = 0x64 gives `acc_out` = 0xFF and `status_out` = 0xA4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Starts an operation; the result is captured on this clock edge |
| op_sub | input | 1 | Operation select: 0 = add with carry, 1 = subtract with borrow |
| operand | input | 8 | Second operand |
| acc_in | input | 8 | Current accumulator value |
| status_in | input | 8 | Current status byte; bit 7 N, bit 6 V, bit 1 Z, bit 0 C |
| acc_out | output | 8 | Registered accumulator result |
| status_out | output | 8 | Registered status byte |

## Verification
The bench aims at the overflow boundary. This includes the opposite-sign sums 0x7F+0x80 and 0x00+0x80, where a unit that flags sign changes would wrongly set V. It also includes the same-sign sums 0x7F+0x01 and 0x80+0xFF, where a unit that ignored the carried-in bit or the inverted operand would miss V. For subtraction it checks both borrow directions and the case of an equal operand. A unit that took the raw operand for V, or inverted carry out, would report the wrong C there. It sets the decimal bit to show that an adjusting unit would produce 0x10 instead of 0x0A. It also changes the inputs during idle cycles, so a unit that captured without a strobe would move its outputs.

// File: rtl/asf_pkg.sv
package asf_pkg;

   typedef enum logic {
      ASF_OP_ADD = 1'b0,
      ASF_OP_SUB = 1'b1
   } asf_op_e;

   typedef struct packed {
      logic neg;
      logic ovf;
      logic zero;
      logic cry;
   } asf_flags_t;

   localparam int ASF_ADDER_INFERRED = 0;
   localparam int ASF_ADDER_RIPPLE   = 1;

   localparam int ASF_OVF_SIGN_CMP   = 0;
   localparam int ASF_OVF_CARRY_XOR  = 1;

endpackage

// File: rtl/asf_operand_prep.sv
module asf_operand_prep
   import asf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  asf_op_e             op,
   input  logic [DATA_W-1:0]   operand,
   output logic [DATA_W-1:0]   eff_operand
);

   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   always_comb begin
      if (op == ASF_OP_SUB) eff_operand = operand ^ ALL_ONES;
      else                  eff_operand = operand;
   end

endmodule

// File: rtl/asf_adder.sv
module asf_adder
   import asf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int STYLE  = ASF_ADDER_INFERRED
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              c_into_msb,
   output logic              cout
);

   localparam int MSB = DATA_W - 1;

   if (STYLE == ASF_ADDER_RIPPLE) begin : g_ripple
      logic [DATA_W:0] carry;
      assign carry[0] = cin;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]     = a[i] ^ b[i] ^ carry[i];
         assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
      assign c_into_msb = carry[MSB];
      assign cout       = carry[DATA_W];
   end else begin : g_inferred
      logic [MSB:0] low;
      always_comb begin
         low        = {1'b0, a[MSB-1:0]} + {1'b0, b[MSB-1:0]} + {{MSB{1'b0}}, cin};
         c_into_msb = low[MSB];
         sum        = {a[MSB] ^ b[MSB] ^ low[MSB], low[MSB-1:0]};
         cout       = (a[MSB] & b[MSB]) | (low[MSB] & (a[MSB] ^ b[MSB]));
      end
   end

endmodule

// File: rtl/asf_flag_gen.sv
module asf_flag_gen
   import asf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OVF_STYLE = ASF_OVF_SIGN_CMP
) (
   input  logic              a_msb,
   input  logic              b_msb,
   input  logic [DATA_W-1:0] sum,
   input  logic              c_into_msb,
   input  logic              cout,
   output asf_flags_t        flags,
   output logic              ovf_alt
);

   logic ovf_cmp;
   logic ovf_cry;

   assign ovf_cmp = (a_msb == b_msb) && (sum[DATA_W-1] != a_msb);
   assign ovf_cry = c_into_msb ^ cout;

   if (OVF_STYLE == ASF_OVF_CARRY_XOR) begin : g_ovf_cry
      assign flags.ovf = ovf_cry;
      assign ovf_alt   = ovf_cmp;
   end else begin : g_ovf_cmp
      assign flags.ovf = ovf_cmp;
      assign ovf_alt   = ovf_cry;
   end

   assign flags.neg  = sum[DATA_W-1];
   assign flags.zero = (sum == '0);
   assign flags.cry  = cout;

endmodule

// File: rtl/asf_unit.sv
module asf_unit
   import asf_pkg::*;
#(
   parameter int                 DATA_W      = 8,
   parameter int                 STAT_W      = 8,
   parameter int                 N_POS       = 7,
   parameter int                 V_POS       = 6,
   parameter int                 Z_POS       = 1,
   parameter int                 C_POS       = 0,
   parameter logic [DATA_W-1:0]  RST_ACC     = '0,
   parameter logic [STAT_W-1:0]  RST_STAT    = 'h24,
   parameter int                 ADDER_STYLE = ASF_ADDER_INFERRED,
   parameter int                 OVF_STYLE   = ASF_OVF_SIGN_CMP
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              op_sub,
   input  logic [7:0]        operand,
   input  logic [7:0]        acc_in,
   input  logic [7:0]        status_in,
   output logic [7:0]        acc_out,
   output logic [7:0]        status_out
);

   localparam int MSB = DATA_W - 1;
   localparam logic [STAT_W-1:0] OWN_MASK =
      STAT_W'((1 << N_POS) | (1 << V_POS) | (1 << Z_POS) | (1 << C_POS));
   localparam logic [STAT_W-1:0] PASS_MASK = ~OWN_MASK;

   // elaboration-time parameter checks
   if (DATA_W != 8 || STAT_W != 8) begin : g_bad_width
      $error("asf_unit: port widths are fixed at 8 bits");
   end
   if (N_POS >= STAT_W || V_POS >= STAT_W || Z_POS >= STAT_W || C_POS >= STAT_W) begin : g_bad_pos
      $error("asf_unit: flag position outside status byte");
   end
   if (N_POS == V_POS || N_POS == Z_POS || N_POS == C_POS ||
       V_POS == Z_POS || V_POS == C_POS || Z_POS == C_POS) begin : g_dup_pos
      $error("asf_unit: flag positions must be distinct");
   end
   if (ADDER_STYLE != ASF_ADDER_INFERRED && ADDER_STYLE != ASF_ADDER_RIPPLE) begin : g_bad_adder
      $error("asf_unit: unknown ADDER_STYLE");
   end
   if (OVF_STYLE != ASF_OVF_SIGN_CMP && OVF_STYLE != ASF_OVF_CARRY_XOR) begin : g_bad_ovf
      $error("asf_unit: unknown OVF_STYLE");
   end

   asf_op_e            op;
   logic [DATA_W-1:0]  eff_b;
   logic [DATA_W-1:0]  sum;
   logic               c_msb;
   logic               cout;
   asf_flags_t         flags;
   logic               ovf_alt;
   logic [STAT_W-1:0]  next_stat;

   assign op = asf_op_e'(op_sub);

   asf_operand_prep #(.DATA_W(DATA_W)) prep_i (
      .op          (op),
      .operand     (operand),
      .eff_operand (eff_b)
   );

   asf_adder #(.DATA_W(DATA_W), .STYLE(ADDER_STYLE)) add_i (
      .a          (acc_in),
      .b          (eff_b),
      .cin        (status_in[C_POS]),
      .sum        (sum),
      .c_into_msb (c_msb),
      .cout       (cout)
   );

   asf_flag_gen #(.DATA_W(DATA_W), .OVF_STYLE(OVF_STYLE)) flg_i (
      .a_msb      (acc_in[MSB]),
      .b_msb      (eff_b[MSB]),
      .sum        (sum),
      .c_into_msb (c_msb),
      .cout       (cout),
      .flags      (flags),
      .ovf_alt    (ovf_alt)
   );

   for (genvar i = 0; i < STAT_W; i++) begin : g_stat
      if (i == N_POS) begin : g_n
         assign next_stat[i] = flags.neg;
      end else if (i == V_POS) begin : g_v
         assign next_stat[i] = flags.ovf;
      end else if (i == Z_POS) begin : g_z
         assign next_stat[i] = flags.zero;
      end else if (i == C_POS) begin : g_c
         assign next_stat[i] = flags.cry;
      end else begin : g_pass
         assign next_stat[i] = status_in[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_out    <= RST_ACC;
         status_out <= RST_STAT;
      end else if (in_valid) begin
         acc_out    <= sum;
         status_out <= next_stat;
      end
   end

   // R8: no strobe, no change
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(acc_out) && $stable(status_out)));

   // R7: unowned status bits pass through
   p_pass_bits_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (((status_out ^ $past(status_in)) & PASS_MASK) == '0));

   // R6: N tracks result sign, Z tracks zero result
   p_neg_sign_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (status_out[N_POS] == acc_out[MSB]));
   p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (status_out[Z_POS] == (acc_out == '0)));

   // R3: opposite-sign adder inputs never overflow
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (acc_in[MSB] != eff_b[MSB])) |=> !status_out[V_POS]);

   // R3: both overflow formulations agree
   p_ovf_agree_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (flags.ovf == ovf_alt));

   // R5: subtracting a larger value with no pending borrow clears carry
   p_borrow_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sub && status_in[C_POS] && (operand > acc_in)) |=> !status_out[C_POS]);

   // R4: subtracting an equal value with carry set gives zero and no borrow
   p_sub_equal_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sub && status_in[C_POS] && (operand == acc_in))
         |=> (acc_out == '0 && status_out[C_POS]));

endmodule

// File: tb/asf_unit_tb_top.sv
`timescale 1ns/1ps
module asf_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       in_valid;
   logic       op_sub;
   logic [7:0] operand;
   logic [7:0] acc_in;
   logic [7:0] status_in;
   logic [7:0] acc_out;
   logic [7:0] status_out;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   bit live     = 1'b0;
   string cur_req = "R1";

   int m_acc;
   int m_st;

   always #2 clk = ~clk;

   asf_unit dut_i (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .op_sub     (op_sub),
      .operand    (operand),
      .acc_in     (acc_in),
      .status_in  (status_in),
      .acc_out    (acc_out),
      .status_out (status_out)
   );

   // behavioural reference model, updated at each rising edge
   always @(posedge clk) begin
      if (rst) begin
         m_acc = 0;
         m_st  = 'h24;
         live  = 1'b1;
      end else if (in_valid && live) begin
         int a, b, c, u, res, sa, sb, s, v;
         a  = acc_in;
         b  = op_sub ? ((~operand) & 8'hFF) : operand;
         c  = status_in & 1;
         u  = a + b + c;
         res = u % 256;
         sa = (a >= 128) ? a - 256 : a;
         sb = (b >= 128) ? b - 256 : b;
         s  = sa + sb + c;
         v  = (s < -128 || s > 127) ? 1 : 0;
         m_acc = res;
         m_st  = (status_in & 'h3C) | ((res >= 128) ? 'h80 : 0) | (v << 6)
               | ((res == 0) ? 'h02 : 0) | ((u > 255) ? 1 : 0);
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (live && !done) begin
         checks++;
         if (acc_out !== 8'(m_acc) || status_out !== 8'(m_st)) begin
            failures++;
            $display("FAIL %s model: acc=%02h st=%02h expected acc=%02h st=%02h",
                     cur_req, acc_out, status_out, m_acc[7:0], m_st[7:0]);
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
      end
   endtask

   task automatic do_op(input string req, input logic sub, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] st);
      @(negedge clk);
      cur_req   = req;
      in_valid  = 1'b1;
      op_sub    = sub;
      acc_in    = a;
      operand   = b;
      status_in = st;
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0;
      operand = '0; acc_in = '0; status_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 acc", acc_out, 8'h00);
      chk("R1 status", status_out, 8'h24);
      rst = 1'b0;

      // R9 reference example
      do_op("R9", 1'b0, 8'h7F, 8'h80, 8'h64);
      chk("R9 acc", acc_out, 8'hFF);
      chk("R9 status", status_out, 8'hA4);

      // R3 opposite signs: 0 + 0x80
      do_op("R3", 1'b0, 8'h00, 8'h80, 8'h24);
      chk("R3 acc 0+80", acc_out, 8'h80);
      chk("R3 status 0+80", status_out, 8'hA4);

      // R3 same sign positive overflow
      do_op("R3", 1'b0, 8'h7F, 8'h01, 8'h24);
      chk("R3 acc 7F+01", acc_out, 8'h80);
      chk("R3 status 7F+01", status_out, 8'hE4);

      // R3 R5 same sign negative overflow with carry out
      do_op("R5", 1'b0, 8'h80, 8'hFF, 8'h24);
      chk("R3 acc 80+FF", acc_out, 8'h7F);
      chk("R5 status 80+FF", status_out, 8'h65);

      // R2 carry in counted
      do_op("R2", 1'b0, 8'h10, 8'h20, 8'h25);
      chk("R2 acc 10+20+1", acc_out, 8'h31);

      // R6 zero with carry
      do_op("R6", 1'b0, 8'hFF, 8'h01, 8'h24);
      chk("R6 acc FF+01", acc_out, 8'h00);
      chk("R6 status FF+01", status_out, 8'h27);

      // R4 R5 subtract, no borrow
      do_op("R4", 1'b1, 8'h50, 8'h10, 8'h25);
      chk("R4 acc 50-10", acc_out, 8'h40);
      chk("R5 status 50-10", status_out, 8'h25);

      // R5 subtract with borrow
      do_op("R5", 1'b1, 8'h10, 8'h20, 8'h25);
      chk("R5 acc 10-20", acc_out, 8'hF0);
      chk("R5 status 10-20", status_out, 8'hA4);

      // R4 borrow in (C clear)
      do_op("R4", 1'b1, 8'h05, 8'h03, 8'h24);
      chk("R4 acc 05-03-1", acc_out, 8'h01);

      // R3 subtract overflow 0x80 - 0x01
      do_op("R3", 1'b1, 8'h80, 8'h01, 8'h25);
      chk("R3 acc 80-01", acc_out, 8'h7F);
      chk("R3 status 80-01", status_out, 8'h65);

      // R7 decimal bit ignored, unowned bits pass
      do_op("R7", 1'b0, 8'h09, 8'h01, 8'h3C);
      chk("R7 acc 09+01 binary", acc_out, 8'h0A);
      chk("R7 status pass", status_out, 8'h3C);

      // R8 inputs move, no strobe
      @(negedge clk);
      cur_req = "R8";
      acc_in = 8'h12; operand = 8'h34; status_in = 8'hC3; op_sub = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 acc hold", acc_out, 8'h0A);
      chk("R8 status hold", status_out, 8'h3C);

      // broad random sweep against the model
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         cur_req   = "R2";
         in_valid  = ($urandom_range(0, 3) != 0);
         op_sub    = 1'($urandom_range(0, 1));
         if (op_sub) cur_req = "R4";
         acc_in    = 8'($urandom_range(0, 255));
         operand   = 8'($urandom_range(0, 255));
         status_in = 8'($urandom_range(0, 255));
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule